// File: doc/BRIEF.md
# Fetch-and-Add Decombining Wait Buffer

In a combining switch, two fetch-and-add requests that hit the same memory word can be merged into one forward request whose addend is the sum of both. This block keeps what is needed to undo that merge. At merge time it stores a record with three items: the tag of the merged request, the addend of the request placed first in the serial order, and a flag that says whether that request came from the upper or the lower port. When the single reply for the tag comes back, the block finds the record and builds two replies. The request placed first gets the returned value unchanged. The other request gets the returned value plus the stored addend. Both results are then the same as if the two requests had reached memory one after the other.

The record store has a parameter for its depth, because depth sets how much combining the switch can do. A full flag tells the switch to stop accepting memory-bound traffic. A reply whose tag matches no record goes out unchanged on the upper output. Each reply output has its own register and its own ready signal, so either output can hold its reply while the other drains.

Top module: `faa_decombiner`

## Requirements
- R1: A merge presented while `bufFull` is low is stored. `bufFull` is high exactly when all DEPTH records are occupied. A merge presented while `bufFull` is high is dropped, so a later reply with its tag is treated as unmatched.
- R2: For a matched record with `mergeUpperFirst`=1, the accepted reply value r appears on `upData` unchanged, and r plus the stored addend appears on `loData`. Both outputs become valid in the cycle after the reply is accepted.
- R3: For a matched record with `mergeUpperFirst`=0, r appears on `loData` and r plus the stored addend appears on `upData`.
- R4: The sum wraps modulo 2^DATA_W.
- R5: For a reply whose tag matches no record, r appears on `upData` and `loValid` stays low.
- R6: A record is freed in the cycle its reply is accepted. `bufFull` drops on the next cycle, and a second reply with the same tag is then unmatched.
- R7: `replyReady` is low while either output register holds a reply. Each output keeps its valid and data until its own ready is high, so the second reply waits while the first leaves.
- R8: `upTag` and `loTag` both carry the tag of the accepted reply.
- R9: After reset, no record is occupied, `bufFull` is 0, both outputs are invalid and `replyReady` is 1.
- R10: With merges nested over two levels, feeding each level's replies into the level below gives every original request the start value plus the sum of the addends ordered before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mergeValid | input | 1 | Record a merged pair |
| mergeTag | input | TAG_W | Tag of the merged forward request |
| mergeAddend | input | DATA_W | Addend of the request placed first |
| mergeUpperFirst | input | 1 | 1: the upper-port request is placed first |
| bufFull | output | 1 | All records occupied; backpressure |
| replyValid | input | 1 | Reply from memory present |
| replyTag | input | TAG_W | Tag of the reply |
| replyData | input | DATA_W | Returned value |
| replyReady | output | 1 | Reply accepted this cycle if valid |
| upValid | output | 1 | Upper reply valid |
| upReady | input | 1 | Upper reply taken |
| upTag | output | TAG_W | Upper reply tag |
| upData | output | DATA_W | Upper reply value |
| loValid | output | 1 | Lower reply valid |
| loReady | input | 1 | Lower reply taken |
| loTag | output | TAG_W | Lower reply tag |
| loData | output | DATA_W | Lower reply value |

## Verification
The hardest case to reach is a nested merge. There the replies from an upper level must become the inputs to a lower level, and every final value must match one serial order. The bench records three merges in the same buffer: two leaf pairs and one parent pair whose addend is the sum of the first leaf. It then returns the parent reply and uses the two values it gets back as the leaf replies. Backpressure with a full buffer is the other hard case. The bench fills every record, presents one more merge, and then shows through an unmatched reply that this merge was never stored.

// File: rtl/faa_pkg.sv
package faa_pkg;
  typedef struct packed {
    logic alloc;     // write a record at the allocation slot
    logic loadHit;   // load both output registers from a matched reply
    logic loadMiss;  // load upper output register only
  } faaStrobes_t;
endpackage

// File: rtl/faa_ctrl.sv
module faa_ctrl
  import faa_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mergeValid,
  input  logic             replyValid,
  input  logic [DEPTH-1:0] hitVec,
  input  logic             upReady,
  input  logic             loReady,
  output logic             bufFull,
  output logic             replyReady,
  output logic             upValid,
  output logic             loValid,
  output logic [DEPTH-1:0] validVec,
  output logic [DEPTH-1:0] allocOneHot,
  output faaStrobes_t      strobes
);
  logic [DEPTH-1:0] validQ;
  logic             upQ, loQ;
  logic             accept, hit;
  logic [DEPTH-1:0] freeMask, setMask;

  always_comb begin
    allocOneHot = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validQ[i]) allocOneHot = '0;
      if (!validQ[i]) allocOneHot[i] = 1'b1;
    end
  end

  assign bufFull    = &validQ;
  assign replyReady = !upQ && !loQ;
  assign accept     = replyValid && replyReady;
  assign hit        = |hitVec;

  assign strobes.alloc    = mergeValid && !bufFull;
  assign strobes.loadHit  = accept && hit;
  assign strobes.loadMiss = accept && !hit;

  assign freeMask = strobes.loadHit ? hitVec : '0;
  assign setMask  = strobes.alloc ? allocOneHot : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      upQ    <= 1'b0;
      loQ    <= 1'b0;
    end else begin
      validQ <= (validQ & ~freeMask) | setMask;
      if (accept)       upQ <= 1'b1;
      else if (upReady) upQ <= 1'b0;
      if (strobes.loadHit) loQ <= 1'b1;
      else if (loReady)    loQ <= 1'b0;
    end
  end

  assign validVec = validQ;
  assign upValid  = upQ;
  assign loValid  = loQ;

  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFull && !(replyValid && replyReady) |=> bufFull);

  // R6
  free_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    replyValid && replyReady && hit && !mergeValid |=> !bufFull);
endmodule

// File: rtl/faa_datapath.sv
module faa_datapath
  import faa_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  faaStrobes_t       strobes,
  input  logic [DEPTH-1:0]  allocOneHot,
  input  logic [DEPTH-1:0]  validVec,
  input  logic [TAG_W-1:0]  mergeTag,
  input  logic [DATA_W-1:0] mergeAddend,
  input  logic              mergeUpperFirst,
  input  logic [TAG_W-1:0]  replyTag,
  input  logic [DATA_W-1:0] replyData,
  output logic [DEPTH-1:0]  hitVec,
  output logic [DATA_W-1:0] upData,
  output logic [DATA_W-1:0] loData,
  output logic [TAG_W-1:0]  outTag
);
  logic [TAG_W-1:0]  tagQ [DEPTH];
  logic [DATA_W-1:0] addQ [DEPTH];
  logic              firstUpQ [DEPTH];
  logic [DATA_W-1:0] selAdd, sum;
  logic              selUp;
  logic [DATA_W-1:0] upQ, loQ;
  logic [TAG_W-1:0]  tagOutQ;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign hitVec[g] = validVec[g] && (tagQ[g] == replyTag);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagQ[g]     <= '0;
        addQ[g]     <= '0;
        firstUpQ[g] <= 1'b0;
      end else if (strobes.alloc && allocOneHot[g]) begin
        tagQ[g]     <= mergeTag;
        addQ[g]     <= mergeAddend;
        firstUpQ[g] <= mergeUpperFirst;
      end
    end
  end

  always_comb begin
    selAdd = '0;
    selUp  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      selAdd = selAdd | (hitVec[i] ? addQ[i] : '0);
      selUp  = selUp | (hitVec[i] && firstUpQ[i]);
    end
  end

  assign sum = replyData + selAdd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ     <= '0;
      loQ     <= '0;
      tagOutQ <= '0;
    end else if (strobes.loadHit) begin
      upQ     <= selUp ? replyData : sum;
      loQ     <= selUp ? sum : replyData;
      tagOutQ <= replyTag;
    end else if (strobes.loadMiss) begin
      upQ     <= replyData;
      tagOutQ <= replyTag;
    end
  end

  assign upData = upQ;
  assign loData = loQ;
  assign outTag = tagOutQ;

  // R2
  hit_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadHit && selUp |=> upQ == $past(replyData));

  // R3
  hit_lower_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadHit && !selUp |=> loQ == $past(replyData));
endmodule

// File: rtl/faa_decombiner.sv
module faa_decombiner
  import faa_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mergeValid,
  input  logic [TAG_W-1:0]  mergeTag,
  input  logic [DATA_W-1:0] mergeAddend,
  input  logic              mergeUpperFirst,
  output logic              bufFull,
  input  logic              replyValid,
  input  logic [TAG_W-1:0]  replyTag,
  input  logic [DATA_W-1:0] replyData,
  output logic              replyReady,
  output logic              upValid,
  input  logic              upReady,
  output logic [TAG_W-1:0]  upTag,
  output logic [DATA_W-1:0] upData,
  output logic              loValid,
  input  logic              loReady,
  output logic [TAG_W-1:0]  loTag,
  output logic [DATA_W-1:0] loData
);
  faaStrobes_t      strobes;
  logic [DEPTH-1:0] hitVec, validVec, allocOneHot;
  logic [TAG_W-1:0] outTag;

  faa_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .mergeValid(mergeValid), .replyValid(replyValid),
    .hitVec(hitVec), .upReady(upReady), .loReady(loReady), .bufFull(bufFull),
    .replyReady(replyReady), .upValid(upValid), .loValid(loValid),
    .validVec(validVec), .allocOneHot(allocOneHot), .strobes(strobes)
  );

  faa_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .allocOneHot(allocOneHot),
    .validVec(validVec), .mergeTag(mergeTag), .mergeAddend(mergeAddend),
    .mergeUpperFirst(mergeUpperFirst), .replyTag(replyTag),
    .replyData(replyData), .hitVec(hitVec), .upData(upData),
    .loData(loData), .outTag(outTag)
  );

  assign upTag = outTag;
  assign loTag = outTag;

  // R5
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    replyValid && replyReady && !(|hitVec) |=> upValid && !loValid && upData == $past(replyData));

  // R7
  hold_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    upValid && !upReady |=> upValid && $stable(upData));

  // R7
  lo_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loValid) |-> $rose(upValid));
endmodule

// File: tb/tb_faa_decombiner.sv
module tb_faa_decombiner;
  localparam int DEPTH = 4, DATA_W = 16, TAG_W = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic mergeValid = 0, mergeUpperFirst = 0, replyValid = 0, upReady = 0, loReady = 0;
  logic [TAG_W-1:0]  mergeTag = '0, replyTag = '0, upTag, loTag;
  logic [DATA_W-1:0] mergeAddend = '0, replyData = '0, upData, loData;
  logic bufFull, replyReady, upValid, loValid;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  faa_decombiner #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doMerge(logic [TAG_W-1:0] t, logic [DATA_W-1:0] a, logic uf);
    @(negedge clk);
    mergeValid = 1; mergeTag = t; mergeAddend = a; mergeUpperFirst = uf;
    @(posedge clk);
    @(negedge clk);
    mergeValid = 0;
  endtask

  task automatic doReply(logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    @(negedge clk);
    replyValid = 1; replyTag = t; replyData = d;
    @(posedge clk);
    @(negedge clk);
    replyValid = 0;
  endtask

  task automatic popBoth();
    upReady = 1; loReady = 1;
    @(posedge clk);
    @(negedge clk);
    upReady = 0; loReady = 0;
  endtask

  task automatic tReset();
    check("R9 bufFull", bufFull, 0);
    check("R9 upValid", upValid, 0);
    check("R9 loValid", loValid, 0);
    check("R9 replyReady", replyReady, 1);
  endtask

  task automatic tUpperFirst();
    doMerge(3, 4, 1);
    doReply(3, 0);
    check("R2 upValid", upValid, 1);
    check("R2 upData", upData, 0);
    check("R2 loValid", loValid, 1);
    check("R2 loData", loData, 4);
    check("R8 upTag", upTag, 3);
    check("R8 loTag", loTag, 3);
    popBoth();
  endtask

  task automatic tLowerFirst();
    doMerge(5, 7, 0);
    doReply(5, 100);
    check("R3 loData", loData, 100);
    check("R3 upData", upData, 107);
    popBoth();
  endtask

  task automatic tWrap();
    doMerge(7, 16'hFFF0, 1);
    doReply(7, 16'h0020);
    check("R4 upData", upData, 16'h0020);
    check("R4 loData wraps", loData, 16'h0010);
    popBoth();
  endtask

  task automatic tMiss();
    doReply(9, 55);
    check("R5 upValid", upValid, 1);
    check("R5 upData", upData, 55);
    check("R5 loValid", loValid, 0);
    check("R5 upTag", upTag, 9);
    popBoth();
  endtask

  task automatic tFull();
    for (int i = 0; i < DEPTH; i++) begin
      check("R1 not full while filling", bufFull, 0);
      doMerge(TAG_W'(i), DATA_W'(10 + i), 1);
    end
    check("R1 full", bufFull, 1);
    doMerge(10, 99, 1);
    doReply(10, 5);
    check("R1 dropped merge is unmatched", loValid, 0);
    check("R1 dropped merge passthrough", upData, 5);
    popBoth();
    doReply(0, 1);
    check("R6 freed on accept", bufFull, 0);
    check("R2 full-test loData", loData, 11);
    popBoth();
    doReply(0, 2);
    check("R6 second reply unmatched", loValid, 0);
    popBoth();
    for (int i = 1; i < DEPTH; i++) begin
      doReply(TAG_W'(i), 0);
      check("R2 drain loData", loData, 32'(10 + i));
      popBoth();
    end
  endtask

  task automatic tHold();
    doMerge(6, 3, 1);
    doReply(6, 20);
    check("R7 ready low while held", replyReady, 0);
    upReady = 1; loReady = 0;
    @(posedge clk);
    @(negedge clk);
    upReady = 0;
    check("R7 upper drained", upValid, 0);
    check("R7 lower held", loValid, 1);
    check("R7 lower data held", loData, 23);
    check("R7 ready still low", replyReady, 0);
    loReady = 1;
    @(posedge clk);
    @(negedge clk);
    loReady = 0;
    check("R7 lower drained", loValid, 0);
    check("R7 ready back", replyReady, 1);
  endtask

  task automatic tNested();
    logic [DATA_W-1:0] pUp, pLo, r1, r2, r4, r8;
    // leaves: (1 upper,2 lower) tag1, (4 upper,8 lower) tag2; parent (3 upper,12 lower) tag3
    doMerge(1, 1, 1);
    doMerge(2, 4, 1);
    doMerge(3, 3, 1);
    doReply(3, 0);
    pUp = upData; pLo = loData;
    popBoth();
    doReply(1, pUp);
    r1 = upData; r2 = loData;
    popBoth();
    doReply(2, pLo);
    r4 = upData; r8 = loData;
    popBoth();
    check("R10 first", r1, 0);
    check("R10 second", r2, 1);
    check("R10 third", r4, 3);
    check("R10 fourth", r8, 7);
    check("R10 final memory", 32'(r8 + 8), 15);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tUpperFirst();
    tLowerFirst();
    tWrap();
    tMiss();
    tFull();
    tHold();
    tNested();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule